// File: doc/BRIEF.md
# Bit-Interleaved Parity Striping Unit

This block spreads each data byte over a row of independent storage lanes, one bit per lane, and feeds one extra lane with a check bit so the nine lane bits of a byte always have even parity. A byte offered on the valid/ready write port is encoded and appears on the lane write lines one clock later, with a write strobe. A byte transfer always uses every lane in the same cycle.

On a read request the block samples the nine lane read lines and a per-lane failure mask in the same cycle. One clock later it presents the rebuilt byte. If exactly one data lane is marked failed, that lane's bit is rebuilt from the other eight lanes. If only the check lane is marked failed, the data lanes pass through as they are. With no lane marked failed, a parity violation is reported and the data is still returned. With two or more lanes marked failed, the byte cannot be recovered: an error is flagged and no valid data is returned. A read request has priority over a write in the same cycle.

Top module: `bitlane_parity_stripe`

## Requirements
- R1: `wr_ready` is the inverse of `rd_req`; a write is accepted only in a cycle with `wr_valid` high and `wr_ready` high.
- R2: One cycle after an accepted write, `lane_wr_en` is 1 and `lane_wr_bits[i]` equals bit i of the accepted byte for i = 0..7.
- R3: Whenever `lane_wr_en` is 1, `lane_wr_bits[8]` is the XOR of bits 0..7, so the XOR of all nine lane bits is 0.
- R4: In the cycle after a cycle with no accepted write, `lane_wr_en` is 0.
- R5: One cycle after `rd_req` with `lane_fail` all zero, `rd_valid` is 1 and `rd_data` equals `lane_rd_bits[7:0]` as sampled.
- R6: On a read with `lane_fail` all zero, `rd_parity_err` is 1 one cycle later exactly when the XOR of the nine sampled lane bits is 1; `rd_data` is still the sampled lanes 0..7.
- R7: On a read with exactly one data lane i (0..7) marked in `lane_fail`, bit i of `rd_data` is the XOR of the other eight sampled lane bits, whatever value lane i carries; the other bits pass through, `rd_valid` is 1 and `rd_parity_err` is 0.
- R8: On a read with only bit 8 of `lane_fail` set, `rd_data` equals sampled lanes 0..7, `rd_valid` is 1 and `rd_parity_err` is 0.
- R9: On a read with two or more bits of `lane_fail` set, one cycle later `rd_unrec_err` is 1, `rd_valid` is 0 and `rd_data` is 0.
- R10: During and right after reset, `lane_wr_en`, `rd_valid`, `rd_parity_err` and `rd_unrec_err` are 0.
- R11: With no read request, `rd_valid`, `rd_parity_err` and `rd_unrec_err` are 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Write byte offered |
| wr_ready | output | 1 | Write byte can be taken this cycle |
| wr_data | input | 8 | Byte to stripe |
| lane_wr_en | output | 1 | Lane write strobe |
| lane_wr_bits | output | 9 | Lane write bits; bit 8 is the check lane |
| rd_req | input | 1 | Sample lanes for a read this cycle |
| lane_rd_bits | input | 9 | Lane read bits; bit 8 is the check lane |
| lane_fail | input | 9 | Per-lane failure mask, one bit per lane |
| rd_valid | output | 1 | Rebuilt byte is valid |
| rd_data | output | 8 | Rebuilt byte |
| rd_parity_err | output | 1 | Parity violation seen with no lane marked failed |
| rd_unrec_err | output | 1 | Two or more lanes failed; byte lost |

## Verification
The assertions take for granted that `lane_rd_bits` and `lane_fail` only matter in a cycle with `rd_req` high, and that inputs are settled before each rising edge. The stimulus changes every input on the falling edge and holds it for a whole cycle. Clean and rebuilt reads use lane patterns made by encoding a known byte, so the expected byte is that byte. Corrupted lanes are then added on purpose, either on the failed lane or, with an empty mask, on a single lane to force a parity violation.

// File: rtl/bps_pkg.sv
package bps_pkg;
   // Outcome of one read, as classified by the decoder
   typedef enum logic [1:0] {
      RD_CLEAN   = 2'd0,
      RD_REBUILT = 2'd1,
      RD_BAD_PAR = 2'd2,
      RD_LOST    = 2'd3
   } rd_kind_e;
endpackage

// File: rtl/bps_encoder.sv
module bps_encoder #(
   parameter int DATA_W     = 8,
   parameter bit ODD_PARITY = 1'b0
) (
   input  logic [DATA_W-1:0] data_i,
   output logic [DATA_W:0]   lanes_o
);
   localparam int CHK_LANE = DATA_W;

   for (genvar gi = 0; gi < DATA_W; gi++) begin : g_lane
      assign lanes_o[gi] = data_i[gi];
   end

   if (ODD_PARITY) begin : g_odd
      assign lanes_o[CHK_LANE] = ~(^data_i);
   end else begin : g_even
      assign lanes_o[CHK_LANE] = ^data_i;
   end
endmodule

// File: rtl/bps_decoder.sv
module bps_decoder
   import bps_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter bit ODD_PARITY = 1'b0
) (
   input  logic [DATA_W:0]   lanes_i,
   input  logic [DATA_W:0]   fail_i,
   output logic [DATA_W-1:0] data_o,
   output rd_kind_e          kind_o
);
   localparam int NLANE = DATA_W + 1;
   localparam int CNT_W = $clog2(NLANE + 1);

   logic [CNT_W-1:0] fail_cnt;
   logic             good_xor;
   logic             all_xor;

   always_comb begin
      fail_cnt = '0;
      for (int i = 0; i < NLANE; i++) begin
         fail_cnt = fail_cnt + CNT_W'(fail_i[i]);
      end
   end

   // XOR over surviving lanes: equals the missing bit when one lane is out
   assign good_xor = (^(lanes_i & ~fail_i)) ^ ODD_PARITY;
   assign all_xor  = (^lanes_i) ^ ODD_PARITY;

   for (genvar gi = 0; gi < DATA_W; gi++) begin : g_rebuild
      assign data_o[gi] = fail_i[gi] ? good_xor : lanes_i[gi];
   end

   always_comb begin
      if (fail_cnt > CNT_W'(1))       kind_o = RD_LOST;
      else if (fail_cnt == CNT_W'(1)) kind_o = RD_REBUILT;
      else if (all_xor)               kind_o = RD_BAD_PAR;
      else                            kind_o = RD_CLEAN;
   end
endmodule

// File: rtl/bitlane_parity_stripe.sv
module bitlane_parity_stripe
   import bps_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter bit ODD_PARITY = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_valid,
   output logic              wr_ready,
   input  logic [DATA_W-1:0] wr_data,
   output logic              lane_wr_en,
   output logic [DATA_W:0]   lane_wr_bits,
   input  logic              rd_req,
   input  logic [DATA_W:0]   lane_rd_bits,
   input  logic [DATA_W:0]   lane_fail,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_parity_err,
   output logic              rd_unrec_err
);
   localparam int NLANE = DATA_W + 1;

   if (DATA_W < 2) begin : g_bad_width
      $error("bitlane_parity_stripe: DATA_W must be at least 2");
   end

   logic [NLANE-1:0]  enc_lanes;
   logic [DATA_W-1:0] dec_data;
   rd_kind_e          dec_kind;
   logic              wr_take;

   assign wr_ready = ~rd_req;
   assign wr_take  = wr_valid & wr_ready;

   bps_encoder #(.DATA_W(DATA_W), .ODD_PARITY(ODD_PARITY)) u_enc (
      .data_i  (wr_data),
      .lanes_o (enc_lanes)
   );

   bps_decoder #(.DATA_W(DATA_W), .ODD_PARITY(ODD_PARITY)) u_dec (
      .lanes_i (lane_rd_bits),
      .fail_i  (lane_fail),
      .data_o  (dec_data),
      .kind_o  (dec_kind)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lane_wr_en   <= 1'b0;
         lane_wr_bits <= '0;
      end else begin
         lane_wr_en <= wr_take;
         if (wr_take) lane_wr_bits <= enc_lanes;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_valid      <= 1'b0;
         rd_data       <= '0;
         rd_parity_err <= 1'b0;
         rd_unrec_err  <= 1'b0;
      end else if (rd_req) begin
         rd_valid      <= (dec_kind != RD_LOST);
         rd_data       <= (dec_kind == RD_LOST) ? '0 : dec_data;
         rd_parity_err <= (dec_kind == RD_BAD_PAR);
         rd_unrec_err  <= (dec_kind == RD_LOST);
      end else begin
         rd_valid      <= 1'b0;
         rd_parity_err <= 1'b0;
         rd_unrec_err  <= 1'b0;
      end
   end
endmodule

// File: rtl/bps_checker.sv
module bps_checker #(
   parameter int DATA_W     = 8,
   parameter bit ODD_PARITY = 1'b0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_valid,
   input logic              wr_ready,
   input logic [DATA_W-1:0] wr_data,
   input logic              lane_wr_en,
   input logic [DATA_W:0]   lane_wr_bits,
   input logic              rd_req,
   input logic [DATA_W:0]   lane_rd_bits,
   input logic [DATA_W:0]   lane_fail,
   input logic              rd_valid,
   input logic [DATA_W-1:0] rd_data,
   input logic              rd_parity_err,
   input logic              rd_unrec_err
);
   p_ready_r1: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |-> !wr_ready);

   p_wr_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && wr_ready) |=> (lane_wr_en && lane_wr_bits[DATA_W-1:0] == $past(wr_data)));

   p_lane_parity_r3: assert property (@(posedge clk) disable iff (!rst_n)
      lane_wr_en |-> ((^lane_wr_bits) == ODD_PARITY));

   p_wr_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_valid && wr_ready) |=> !lane_wr_en);

   p_clean_rd_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && lane_fail == '0) |=> (rd_valid && rd_data == $past(lane_rd_bits[DATA_W-1:0])));

   p_par_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && lane_fail == '0) |=> (rd_parity_err == $past(((^lane_rd_bits) ^ ODD_PARITY))));

   p_lost_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && $countones(lane_fail) > 1) |=> (rd_unrec_err && !rd_valid && rd_data == '0));

   p_no_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_req |=> (!rd_valid && !rd_parity_err && !rd_unrec_err));
endmodule

bind bitlane_parity_stripe bps_checker #(.DATA_W(DATA_W), .ODD_PARITY(ODD_PARITY)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .wr_valid      (wr_valid),
   .wr_ready      (wr_ready),
   .wr_data       (wr_data),
   .lane_wr_en    (lane_wr_en),
   .lane_wr_bits  (lane_wr_bits),
   .rd_req        (rd_req),
   .lane_rd_bits  (lane_rd_bits),
   .lane_fail     (lane_fail),
   .rd_valid      (rd_valid),
   .rd_data       (rd_data),
   .rd_parity_err (rd_parity_err),
   .rd_unrec_err  (rd_unrec_err)
);

// File: tb/sim_bitlane_parity_stripe.sv
`timescale 1ns/1ps
module sim_bitlane_parity_stripe;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_valid = 1'b0;
   logic       wr_ready;
   logic [7:0] wr_data = '0;
   logic       lane_wr_en;
   logic [8:0] lane_wr_bits;
   logic       rd_req = 1'b0;
   logic [8:0] lane_rd_bits = '0;
   logic [8:0] lane_fail = '0;
   logic       rd_valid;
   logic [7:0] rd_data;
   logic       rd_parity_err;
   logic       rd_unrec_err;

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;
   bit done = 1'b0;
   int unsigned seed_v;

   always #5 clk = ~clk;

   bitlane_parity_stripe u0 (
      .clk(clk), .rst_n(rst_n),
      .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
      .lane_wr_en(lane_wr_en), .lane_wr_bits(lane_wr_bits),
      .rd_req(rd_req), .lane_rd_bits(lane_rd_bits), .lane_fail(lane_fail),
      .rd_valid(rd_valid), .rd_data(rd_data),
      .rd_parity_err(rd_parity_err), .rd_unrec_err(rd_unrec_err)
   );

   function automatic logic [8:0] encode(input logic [7:0] b);
      logic p = 1'b0;
      for (int i = 0; i < 8; i++) p = p ^ b[i];
      return {p, b};
   endfunction

   function automatic int ones9(input logic [8:0] v);
      int c = 0;
      for (int i = 0; i < 9; i++) c += int'(v[i]);
      return c;
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   // write one byte: drive at negedge, lanes appear after the next posedge
   task automatic do_write(input logic [7:0] b, input logic with_rd);
      wr_valid = 1'b1; wr_data = b; rd_req = with_rd;
      lane_rd_bits = encode(8'h00); lane_fail = '0;
      #1;
      check("R1 wr_ready", 32'(wr_ready), 32'(!with_rd));
      @(negedge clk);
      wr_valid = 1'b0; rd_req = 1'b0;
      if (with_rd) begin
         check("R1 read wins, no lane write", 32'(lane_wr_en), 32'd0);
      end else begin
         check("R2 lane_wr_en", 32'(lane_wr_en), 32'd1);
         check("R2/R3 lane bits", 32'(lane_wr_bits), 32'(encode(b)));
      end
      @(negedge clk);
      check("R4 idle strobe", 32'(lane_wr_en), 32'd0);
   endtask

   // read: returns after the output cycle has been checked
   task automatic do_read(input logic [8:0] lanes, input logic [8:0] mask,
                          input logic [7:0] exp_byte, input string req);
      int nf = ones9(mask);
      logic par = ^lanes;
      rd_req = 1'b1; lane_rd_bits = lanes; lane_fail = mask;
      @(negedge clk);
      rd_req = 1'b0; lane_rd_bits = $urandom; lane_fail = $urandom;
      if (nf >= 2) begin
         check({req, " R9 unrec"}, 32'(rd_unrec_err), 32'd1);
         check({req, " R9 valid"}, 32'(rd_valid), 32'd0);
         check({req, " R9 data"}, 32'(rd_data), 32'd0);
      end else begin
         check({req, " valid"}, 32'(rd_valid), 32'd1);
         check({req, " data"}, 32'(rd_data), 32'(exp_byte));
         check({req, " parity_err"}, 32'(rd_parity_err), 32'((nf == 0) && par));
         check({req, " unrec"}, 32'(rd_unrec_err), 32'd0);
      end
      @(negedge clk);
      check("R11 idle read outputs", 32'({rd_valid, rd_parity_err, rd_unrec_err}), 32'd0);
   endtask

   initial begin : watchdog
      forever begin
         @(posedge clk);
         cyc++;
         if (cyc > 100000 && !done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=<100000", cyc);
            summary();
         end
      end
   end

   initial begin : stim
      seed_v = $urandom(32'h5A17);
      #2;
      check("R10 reset wr_en", 32'(lane_wr_en), 32'd0);
      check("R10 reset rd", 32'({rd_valid, rd_parity_err, rd_unrec_err}), 32'd0);
      @(negedge clk); @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R10 after reset", 32'({lane_wr_en, rd_valid, rd_parity_err, rd_unrec_err}), 32'd0);

      // directed corners
      do_write(8'h00, 1'b0);
      do_write(8'hFF, 1'b0);
      do_write(8'h01, 1'b0);
      do_write(8'hA5, 1'b1);
      do_read(encode(8'h3C), 9'h000, 8'h3C, "R5 clean");
      do_read(encode(8'h3C) ^ 9'h004, 9'h000, 8'h38, "R6 flipped lane");
      do_read(encode(8'h80) ^ 9'h100, 9'h000, 8'h80, "R6 flipped check lane");
      do_read(encode(8'hC3) ^ 9'h001, 9'h001, 8'hC3, "R7 lane0 rebuilt");
      do_read(encode(8'hC3), 9'h080, 8'hC3, "R7 lane7 good value ignored");
      do_read(encode(8'h5A) ^ 9'h100, 9'h100, 8'h5A, "R8 check lane failed");
      do_read(encode(8'h5A), 9'h003, 8'h00, "R9 two lanes");
      do_read(encode(8'h5A), 9'h1FF, 8'h00, "R9 all lanes");

      for (int k = 0; k < 300; k++) begin
         logic [7:0] b = 8'($urandom);
         int sel = int'($urandom % 5);
         int ln = int'($urandom % 9);
         logic [8:0] enc = encode(b);
         logic [8:0] one = 9'(1) << ln;
         case (sel)
            0: do_write(b, 1'($urandom));
            1: do_read(enc, 9'h000, b, "R5 rand clean");
            2: do_read(enc ^ one, 9'h000, (enc ^ one) & 9'h0FF, "R6 rand flip");
            3: do_read(enc ^ (9'($urandom) & one), one, b,
                       (ln == 8) ? "R8 rand check fail" : "R7 rand rebuild");
            default: begin
               logic [8:0] m = 9'($urandom);
               if (ones9(m) < 2) m = m | 9'h110;
               do_read(9'($urandom), m, 8'h00, "R9 rand multi");
            end
         endcase
      end
      done = 1'b1;
      summary();
   end
endmodule